// File: doc/BRIEF.md
# Segment Translation Cache

This block translates virtual addresses to physical addresses for requests that have already missed the last-level cache and are known not to be synonyms. It keeps a small, fully associative set of segment descriptors. Each descriptor has a start address, a length (the limit) and an offset. A request hits when a valid descriptor covers its address. The physical address is then the virtual address plus that descriptor's offset, and it is returned one cycle after the request is accepted. A hit never starts a tree walk.

On a miss the block latches the address and sends it to an external index-tree walker. The walker returns a segment table index. The block then reads that descriptor from the external 2K-entry segment table. If the descriptor covers the address, the block installs it and returns the translation. If the walker finds no index, or if the returned descriptor does not cover the address, the block returns a fault. Only one miss is handled at a time. While a miss is being resolved, the block holds its request-ready signal low.

Top module: `seg_xlat_cache`

## Requirements
- R1: A request accepted in cycle N that matches a valid entry (start ≤ VA and VA − start < limit) returns rsp_valid=1, rsp_fault=0 and rsp_pa = VA + offset in cycle N+1.
- R2: A request that hits never raises walk_req_valid.
- R3: A request accepted in cycle N that matches no entry raises walk_req_valid for exactly one cycle, in cycle N+1, with walk_req_va equal to the VA. req_ready stays low from then until the response, and requests offered during that time are ignored.
- R4: When the walker answers with found=1 in cycle M, tbl_req_valid pulses in cycle M+1 and tbl_req_idx carries the walker's index.
- R5: When the table answer in cycle K covers the latched VA, the block returns rsp_pa = VA + offset with rsp_fault=0 in cycle K+1 and installs the descriptor, so later requests inside its range hit.
- R6: When the walker answers with found=0 in cycle M, the block returns rsp_valid=1, rsp_fault=1 and rsp_pa=0 in cycle M+1. It reads no table entry and installs nothing.
- R7: When the descriptor from the table does not cover the latched VA, the block returns a fault (rsp_fault=1, rsp_pa=0) and installs nothing.
- R8: When several valid entries cover a VA, the entry with the lowest number supplies the offset.
- R9: A fill goes into the lowest-numbered invalid entry. When all entries are valid, it goes into the entry under a round-robin pointer. The pointer starts at entry 0 and advances by one, wrapping, on each fill that evicts.
- R10: After reset all entries are invalid, req_ready is 1, and rsp_valid, walk_req_valid and tbl_req_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | High when a request can be accepted |
| req_va | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | No segment covers the address |
| rsp_pa | output | 32 | Translated physical address (0 on fault) |
| walk_req_valid | output | 1 | Walk request pulse |
| walk_req_va | output | 32 | Address to look up in the index tree |
| walk_rsp_valid | input | 1 | Walker answer strobe |
| walk_rsp_found | input | 1 | Walker found an index |
| walk_rsp_idx | input | IDX_W | Segment table index |
| tbl_req_valid | output | 1 | Segment table read pulse |
| tbl_req_idx | output | IDX_W | Segment table index to read |
| tbl_rsp_valid | input | 1 | Table answer strobe |
| tbl_rsp_base | input | 32 | Descriptor start address |
| tbl_rsp_limit | input | 32 | Descriptor length |
| tbl_rsp_offset | input | 32 | Descriptor offset |

## Verification
The assertions check several things on every cycle. A hit gives an immediate response and starts no walk. A miss gives a single walk pulse and drops ready. A table read follows only a positive walker answer. A negative walker answer turns into a fault. The entry chosen among overlapping matches is the lowest-numbered one, and a fill never overwrites a valid entry while an invalid one is left.

Only the bench scenarios can show that installed descriptors really serve later hits, that faulting descriptors are never installed, and the exact round-robin eviction order once all 128 entries are full. They also show that requests offered during a stall leave no trace.

// File: rtl/seg_xlat_pkg.sv
package seg_xlat_pkg;

  parameter int SX_VA_W = 32;

  typedef enum logic [1:0] {
    SX_IDLE = 2'd0,
    SX_WALK = 2'd1,
    SX_TBL  = 2'd2
  } sx_state_e;

  typedef struct packed {
    logic [SX_VA_W-1:0] base;
    logic [SX_VA_W-1:0] limit;
    logic [SX_VA_W-1:0] offset;
  } seg_desc_t;

  // Range test written so that base + limit never has to be formed.
  function automatic logic seg_covers(input seg_desc_t d, input logic [SX_VA_W-1:0] va);
    return (va >= d.base) && ((va - d.base) < d.limit);
  endfunction

endpackage

// File: rtl/seg_lookup.sv
module seg_lookup
  import seg_xlat_pkg::*;
#(
  parameter int ENTRIES = 128,
  parameter int EIDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0]  ent_valid,
  input  seg_desc_t           ent_desc [ENTRIES],
  input  logic [SX_VA_W-1:0]  va,
  output logic [ENTRIES-1:0]  match,
  output logic                hit,
  output logic [EIDX_W-1:0]   hit_idx
);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = ent_valid[g] && seg_covers(ent_desc[g], va);
  end

  // Lowest-numbered match wins: scan downward so the last write is the lowest.
  always_comb begin
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) hit_idx = EIDX_W'(i);
    end
  end

  assign hit = |match;

endmodule

// File: rtl/seg_victim.sv
module seg_victim #(
  parameter int ENTRIES = 128,
  parameter int EIDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ENTRIES-1:0] ent_valid,
  input  logic               fill_en,
  output logic [EIDX_W-1:0]  victim,
  output logic               all_valid
);

  logic [EIDX_W-1:0] rr_q;
  logic [EIDX_W-1:0] first_free;

  assign all_valid = &ent_valid;

  always_comb begin
    first_free = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!ent_valid[i]) first_free = EIDX_W'(i);
    end
  end

  assign victim = all_valid ? rr_q : first_free;

  always_ff @(posedge clk) begin
    if (rst) begin
      rr_q <= '0;
    end else if (fill_en && all_valid) begin
      rr_q <= (rr_q == EIDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  // R9: a fill with free entries left never overwrites a valid one.
  assert_fill_free_R9: assert property (@(posedge clk) disable iff (rst)
    (fill_en && !all_valid) |-> !ent_valid[victim]);

endmodule

// File: rtl/seg_xlat_cache.sv
module seg_xlat_cache
  import seg_xlat_pkg::*;
#(
  parameter int ENTRIES = 128,
  parameter int IDX_W   = 11,
  localparam int EIDX_W = $clog2(ENTRIES),
  localparam int VA_W   = SX_VA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_va,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic [VA_W-1:0]   rsp_pa,
  output logic              walk_req_valid,
  output logic [VA_W-1:0]   walk_req_va,
  input  logic              walk_rsp_valid,
  input  logic              walk_rsp_found,
  input  logic [IDX_W-1:0]  walk_rsp_idx,
  output logic              tbl_req_valid,
  output logic [IDX_W-1:0]  tbl_req_idx,
  input  logic              tbl_rsp_valid,
  input  logic [VA_W-1:0]   tbl_rsp_base,
  input  logic [VA_W-1:0]   tbl_rsp_limit,
  input  logic [VA_W-1:0]   tbl_rsp_offset
);

  sx_state_e          state_q;
  logic [VA_W-1:0]    va_q;
  logic [ENTRIES-1:0] valid_q;
  seg_desc_t          desc_q [ENTRIES];

  logic [ENTRIES-1:0] lk_match;
  logic               lk_hit;
  logic [EIDX_W-1:0]  lk_idx;
  logic [EIDX_W-1:0]  victim;
  logic               all_valid;
  seg_desc_t          tbl_desc;
  logic               fill_en;

  assign tbl_desc = '{base: tbl_rsp_base, limit: tbl_rsp_limit, offset: tbl_rsp_offset};
  assign req_ready = (state_q == SX_IDLE);
  assign fill_en = (state_q == SX_TBL) && tbl_rsp_valid && seg_covers(tbl_desc, va_q);

  seg_lookup #(.ENTRIES(ENTRIES), .EIDX_W(EIDX_W)) u_lookup (
    .ent_valid (valid_q),
    .ent_desc  (desc_q),
    .va        (req_va),
    .match     (lk_match),
    .hit       (lk_hit),
    .hit_idx   (lk_idx)
  );

  seg_victim #(.ENTRIES(ENTRIES), .EIDX_W(EIDX_W)) u_victim (
    .clk       (clk),
    .rst       (rst),
    .ent_valid (valid_q),
    .fill_en   (fill_en),
    .victim    (victim),
    .all_valid (all_valid)
  );

  // Descriptor storage: no reset, written only on a fill.
  always_ff @(posedge clk) begin
    if (fill_en) desc_q[victim] <= tbl_desc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q        <= SX_IDLE;
      va_q           <= '0;
      valid_q        <= '0;
      rsp_valid      <= 1'b0;
      rsp_fault      <= 1'b0;
      rsp_pa         <= '0;
      walk_req_valid <= 1'b0;
      walk_req_va    <= '0;
      tbl_req_valid  <= 1'b0;
      tbl_req_idx    <= '0;
    end else begin
      rsp_valid      <= 1'b0;
      walk_req_valid <= 1'b0;
      tbl_req_valid  <= 1'b0;
      unique case (state_q)
        SX_IDLE: begin
          if (req_valid) begin
            if (lk_hit) begin
              rsp_valid <= 1'b1;
              rsp_fault <= 1'b0;
              rsp_pa    <= req_va + desc_q[lk_idx].offset;
            end else begin
              va_q           <= req_va;
              walk_req_valid <= 1'b1;
              walk_req_va    <= req_va;
              state_q        <= SX_WALK;
            end
          end
        end
        SX_WALK: begin
          if (walk_rsp_valid) begin
            if (walk_rsp_found) begin
              tbl_req_valid <= 1'b1;
              tbl_req_idx   <= walk_rsp_idx;
              state_q       <= SX_TBL;
            end else begin
              rsp_valid <= 1'b1;
              rsp_fault <= 1'b1;
              rsp_pa    <= '0;
              state_q   <= SX_IDLE;
            end
          end
        end
        SX_TBL: begin
          if (tbl_rsp_valid) begin
            rsp_valid <= 1'b1;
            state_q   <= SX_IDLE;
            if (fill_en) begin
              rsp_fault       <= 1'b0;
              rsp_pa          <= va_q + tbl_rsp_offset;
              valid_q[victim] <= 1'b1;
            end else begin
              rsp_fault <= 1'b1;
              rsp_pa    <= '0;
            end
          end
        end
        default: state_q <= SX_IDLE;
      endcase
    end
  end

  // ---------------- assertions ----------------
  logic [ENTRIES-1:0] lower_mask;
  assign lower_mask = (ENTRIES'(1) << lk_idx) - ENTRIES'(1);

  assert_hit_no_walk_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && lk_hit) |=> (rsp_valid && !rsp_fault && !walk_req_valid));

  assert_miss_walk_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !lk_hit) |=> (walk_req_valid && !req_ready && walk_req_va == $past(req_va)));

  assert_walk_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    walk_req_valid |=> !walk_req_valid);

  assert_tbl_after_found_R4: assert property (@(posedge clk) disable iff (rst)
    tbl_req_valid |-> $past(walk_rsp_valid && walk_rsp_found));

  assert_fill_reply_R5: assert property (@(posedge clk) disable iff (rst)
    fill_en |=> (rsp_valid && !rsp_fault && req_ready));

  assert_notfound_fault_R6: assert property (@(posedge clk) disable iff (rst)
    (state_q == SX_WALK && walk_rsp_valid && !walk_rsp_found) |=> (rsp_valid && rsp_fault && !tbl_req_valid));

  assert_lowest_match_R8: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> (lk_match[lk_idx] && ((lk_match & lower_mask) == '0)));

endmodule

// File: tb/seg_xlat_cache_tb.sv
module seg_xlat_cache_tb;

  localparam int N = 128;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_va = '0;
  logic        rsp_valid, rsp_fault;
  logic [31:0] rsp_pa;
  logic        walk_req_valid;
  logic [31:0] walk_req_va;
  logic        walk_rsp_valid = 1'b0, walk_rsp_found = 1'b0;
  logic [10:0] walk_rsp_idx = '0;
  logic        tbl_req_valid;
  logic [10:0] tbl_req_idx;
  logic        tbl_rsp_valid = 1'b0;
  logic [31:0] tbl_rsp_base = '0, tbl_rsp_limit = '0, tbl_rsp_offset = '0;

  always #10 clk = ~clk;

  seg_xlat_cache u_dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_pa(rsp_pa),
    .walk_req_valid(walk_req_valid), .walk_req_va(walk_req_va),
    .walk_rsp_valid(walk_rsp_valid), .walk_rsp_found(walk_rsp_found), .walk_rsp_idx(walk_rsp_idx),
    .tbl_req_valid(tbl_req_valid), .tbl_req_idx(tbl_req_idx),
    .tbl_rsp_valid(tbl_rsp_valid), .tbl_rsp_base(tbl_rsp_base),
    .tbl_rsp_limit(tbl_rsp_limit), .tbl_rsp_offset(tbl_rsp_offset)
  );

  int nchk = 0;
  int nfail = 0;

  // Reference state
  bit          mv [N];
  logic [31:0] mb [N];
  logic [31:0] ml [N];
  logic [31:0] mo [N];
  int          mrr = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural walker and segment table
  function automatic bit w_found(input logic [31:0] va);
    return va[31:27] == 5'd0;
  endfunction
  function automatic int w_idx(input logic [31:0] va);
    return (va >= 32'h0700_0000) ? 2047 : int'(va[26:16]);
  endfunction
  function automatic logic [31:0] t_base(input int i);
    return (i == 2047) ? 32'h0 : 32'(i) << 16;
  endfunction
  function automatic logic [31:0] t_limit(input int i);
    return (i == 2047) ? 32'h0800_0000 : 32'h0000_8000;
  endfunction
  function automatic logic [31:0] t_off(input int i);
    return (i == 2047) ? 32'h4000_0000 : 32'(i + 1) << 20;
  endfunction

  function automatic int mlook(input logic [31:0] va);
    for (int i = 0; i < N; i++)
      if (mv[i] && va >= mb[i] && (va - mb[i]) < ml[i]) return i;
    return -1;
  endfunction

  // Starts and ends at a negedge.
  task automatic xlat(input logic [31:0] va, input string tag);
    int h;
    h = mlook(va);
    chk(req_ready == 1'b1, {tag, " R3 ready before request"}, 32'(req_ready), 32'd1);
    req_valid = 1'b1; req_va = va;
    @(negedge clk);
    req_valid = 1'b0;
    if (h >= 0) begin
      chk(rsp_valid == 1'b1 && rsp_fault == 1'b0, {tag, " R1 hit response"}, {30'd0, rsp_valid, rsp_fault}, 32'h2);
      chk(rsp_pa == va + mo[h], {tag, " R1/R8 hit pa"}, rsp_pa, va + mo[h]);
      chk(walk_req_valid == 1'b0, {tag, " R2 no walk on hit"}, 32'(walk_req_valid), 32'd0);
    end else begin
      int idx;
      bit fnd;
      chk(walk_req_valid == 1'b1, {tag, " R3 walk pulse"}, 32'(walk_req_valid), 32'd1);
      chk(walk_req_va == va, {tag, " R3 walk va"}, walk_req_va, va);
      chk(req_ready == 1'b0 && rsp_valid == 1'b0, {tag, " R3 stall"}, {30'd0, req_ready, rsp_valid}, 32'd0);
      // offer a request while stalled: must be ignored
      req_valid = 1'b1; req_va = 32'h0000_0010;
      @(negedge clk);
      req_valid = 1'b0;
      chk(walk_req_valid == 1'b0 && req_ready == 1'b0 && rsp_valid == 1'b0, {tag, " R3 single pulse, still stalled"},
          {29'd0, walk_req_valid, req_ready, rsp_valid}, 32'd0);
      fnd = w_found(va);
      idx = w_idx(va);
      walk_rsp_valid = 1'b1; walk_rsp_found = fnd; walk_rsp_idx = 11'(idx);
      @(negedge clk);
      walk_rsp_valid = 1'b0; walk_rsp_found = 1'b0;
      if (!fnd) begin
        chk(rsp_valid && rsp_fault && tbl_req_valid == 1'b0, {tag, " R6 not-found fault"},
            {29'd0, rsp_valid, rsp_fault, tbl_req_valid}, 32'h6);
        chk(rsp_pa == 32'd0, {tag, " R6 fault pa"}, rsp_pa, 32'd0);
      end else begin
        logic [31:0] b, l, o;
        chk(tbl_req_valid == 1'b1 && rsp_valid == 1'b0, {tag, " R4 table read"}, {30'd0, tbl_req_valid, rsp_valid}, 32'h2);
        chk(tbl_req_idx == 11'(idx), {tag, " R4 table index"}, 32'(tbl_req_idx), 32'(idx));
        b = t_base(idx); l = t_limit(idx); o = t_off(idx);
        tbl_rsp_valid = 1'b1; tbl_rsp_base = b; tbl_rsp_limit = l; tbl_rsp_offset = o;
        @(negedge clk);
        tbl_rsp_valid = 1'b0;
        if (va >= b && (va - b) < l) begin
          int v;
          chk(rsp_valid && !rsp_fault, {tag, " R5 fill response"}, {30'd0, rsp_valid, rsp_fault}, 32'h2);
          chk(rsp_pa == va + o, {tag, " R5 fill pa"}, rsp_pa, va + o);
          v = -1;
          for (int i = N - 1; i >= 0; i--) if (!mv[i]) v = i;
          if (v < 0) begin v = mrr; mrr = (mrr + 1) % N; end
          mv[v] = 1'b1; mb[v] = b; ml[v] = l; mo[v] = o;
        end else begin
          chk(rsp_valid && rsp_fault, {tag, " R7 uncovered fault"}, {30'd0, rsp_valid, rsp_fault}, 32'h3);
          chk(rsp_pa == 32'd0, {tag, " R7 fault pa"}, rsp_pa, 32'd0);
        end
      end
    end
    chk(req_ready == 1'b1, {tag, " R3 ready after response"}, 32'(req_ready), 32'd1);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < N; i++) begin mv[i] = 1'b0; mb[i] = '0; ml[i] = '0; mo[i] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(req_ready == 1'b1, "R10 reset ready", 32'(req_ready), 32'd1);
    chk(rsp_valid == 1'b0 && walk_req_valid == 1'b0 && tbl_req_valid == 1'b0, "R10 reset strobes",
        {29'd0, rsp_valid, walk_req_valid, tbl_req_valid}, 32'd0);

    xlat(32'h0003_0010, "R10 first miss");
    xlat(32'h0003_0010, "R1 repeat hit");
    xlat(32'h0003_7FFF, "R1 last covered address");
    xlat(32'h0003_8000, "R7 past limit");
    xlat(32'h0003_8000, "R7 not installed");
    xlat(32'hF000_0000, "R6 walker miss");
    xlat(32'hF000_0000, "R6 not installed");

    for (int k = 10; k <= 136; k++) xlat((32'(k) << 16) | 32'h20, "R9 fill free");
    xlat(32'h00C8_0010, "R9 first eviction");
    xlat(32'h0003_0040, "R9 evicted entry misses");
    xlat(32'h000B_0040, "R9 survivor hits");
    xlat(32'h000A_0040, "R9 second eviction");

    xlat(32'h0700_0010, "R8 wide segment fill");
    xlat(32'h0003_0050, "R8 overlap low entry");
    xlat(32'h0032_0050, "R8 overlap high entry");
    xlat(32'h0258_0010, "R8 wide-only hit");
    xlat(32'h0001_0000, "R8 lower start boundary");

    finish_run();
  end

endmodule